// File: doc/BRIEF.md
# MPLS Label Stack Scanner with Load-Balance Key Extraction

This block sits on the receive path and consumes a packet header as a byte stream whose first byte is the top of an MPLS label stack. It assembles 32-bit label entries, walks down the stack until it meets the entry with the bottom-of-stack bit, and stops early if a bounded search window runs out. Out of what it saw it builds a raw load-balancing key: either the entropy label, or the deepest labels of the stack, optionally joined by the IP source and destination addresses that follow the stack.

A downstream hash unit and forwarding stage consume the result: a stack depth, a malformed flag for discard, an exception flag that sends the packet to a slower path, a key kind and the key fields. The result is presented for exactly one cycle. The input is valid/ready, one byte per cycle, with `in_last` marking the final byte of the packet. A byte moves on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` drops only in the cycle the result is shown. After a result, the rest of the packet is consumed and discarded. The configuration pins must stay steady while a packet is in flight.

Top module: `lstack_scan`

## Requirements
- R1: Each entry is four bytes, most significant byte first. The label sits in bits 31:12, the bottom-of-stack flag in bit 8, and bits 11:9 and 7:0 are ignored. When the entry with the flag set completes, a result follows. `res_depth` counts the entries consumed, including that last one.
- R2: The window holds WINDOW entries. When the WINDOW-th entry completes without the bottom-of-stack flag, the scan ends with `res_depth` = WINDOW. A flagged entry at position WINDOW is still a normal result.
- R3: On a window overrun, `res_exception` is raised when `cfg_slowpath`=1 and `res_malformed` is raised when it is 0. The two flags are never high together. Any result with either flag has an all-zero key and kind 0.
- R4: With no entropy label, the key holds the deepest KEY_DEPTH labels. The bottom entry goes in bits 19:0, the entry above it in 39:20 and the next one up in 59:40. Any position with no label is zero, and `res_kind` = 0 (labels only).
- R5: An entry with label 7 that is not the bottom marks the following entry's label as the entropy label. If more than one such pair appears, the deepest one wins. When a pair is present, `res_key_labels` holds only that label in bits 19:0, `res_kind` = 3, and the payload is not read.
- R6: With `cfg_payload_en`=1 and the high nibble of the first byte after the stack equal to 4, payload bytes 12..19 (counting from 0 at that byte) go into `res_key_ip[63:0]`, with byte 12 most significant. `res_kind` = 1, and the result follows payload byte 19.
- R7: Under the same conditions with a nibble of 6, payload bytes 8..39 go into `res_key_ip[255:0]`, with byte 8 most significant. `res_kind` = 2, and the result follows payload byte 39.
- R8: The key stays labels only (kind 0, `res_key_ip` zero) in each of these cases: payload hashing is disabled, the nibble is any other value (result follows that first payload byte), no byte follows the stack, or the packet ends before the needed payload bytes arrive.
- R9: If `in_last` arrives inside the stack before a bottom-of-stack entry and before the window fills, the result is malformed regardless of `cfg_slowpath`. `res_depth` counts only the whole entries consumed.
- R10: `res_valid` lasts one cycle, and it rises in the cycle after the byte that decides the result. `in_ready` is low in exactly that cycle. Bytes after the deciding byte, up to `in_last`, are consumed and have no effect on the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts a byte |
| in_data | input | 8 | Header byte |
| in_last | input | 1 | Final byte of the packet |
| cfg_slowpath | input | 1 | Window overrun: 1 raises exception, 0 marks malformed |
| cfg_payload_en | input | 1 | Allow IP address fields in the key |
| res_valid | output | 1 | Result strobe, one cycle |
| res_depth | output | $clog2(WINDOW+1) | Entries scanned |
| res_malformed | output | 1 | Discard packet |
| res_exception | output | 1 | Send packet to slow path |
| res_kind | output | 2 | 0 labels, 1 labels+IPv4, 2 labels+IPv6, 3 entropy |
| res_key_labels | output | 20*KEY_DEPTH | Label part of the key |
| res_key_ip | output | 256 | Address part of the key |

## Verification
The assertions check, on every cycle, the rules that concern the result itself:
- the two flags are exclusive;
- the strobe lasts a single cycle;
- the depth stays at or below the window;
- an exception implies a full window;
- an entropy key or a flagged result carries no other fields;
- the payload counter stays within the IPv4 span.

Only the bench's scenarios can show that the right byte decides the result and that the key fields are correct. The same holds for the window boundary, both overrun actions, truncation inside the stack and inside the payload, entropy-pair precedence, and draining of the packet tail. The bench shows these by comparing every result, and its exact cycle, against a behavioural model.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int LABEL_W   = 20;
  localparam int ENTRY_BYTES = 4;
  localparam int IP_KEY_W  = 256;
  localparam logic [LABEL_W-1:0] ELI_VALUE = 20'd7;

  localparam int V4_FIRST = 12;
  localparam int V4_LAST  = 19;
  localparam int V6_FIRST = 8;
  localparam int V6_LAST  = 39;

  typedef enum logic [1:0] {
    KIND_LABELS  = 2'd0,
    KIND_IPV4    = 2'd1,
    KIND_IPV6    = 2'd2,
    KIND_ENTROPY = 2'd3
  } key_kind_e;

  typedef enum logic [1:0] {
    ST_STACK   = 2'd0,
    ST_PAYLOAD = 2'd1,
    ST_RESULT  = 2'd2,
    ST_DRAIN   = 2'd3
  } scan_state_e;
endpackage

// File: rtl/lss_entry_collect.sv
module lss_entry_collect
  import lss_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               take,
  input  logic [7:0]         byte_in,
  output logic               entry_done,
  output logic [LABEL_W-1:0] entry_label,
  output logic               entry_bos
);
  localparam int CNT_W = $clog2(ENTRY_BYTES);
  localparam int ACC_W = 8 * (ENTRY_BYTES - 1);

  logic [CNT_W-1:0] bcnt_q;
  logic [ACC_W-1:0] acc_q;

  // label and flag both live in the first three bytes
  assign entry_done  = take && (bcnt_q == CNT_W'(ENTRY_BYTES - 1));
  assign entry_label = acc_q[ACC_W-1 -: LABEL_W];
  assign entry_bos   = acc_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      bcnt_q <= '0;
      acc_q  <= '0;
    end else if (take) begin
      bcnt_q <= bcnt_q + CNT_W'(1);
      acc_q  <= {acc_q[ACC_W-9:0], byte_in};
    end
  end
endmodule

// File: rtl/lss_label_history.sv
module lss_label_history
  import lss_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     push,
  input  logic [LABEL_W-1:0]       label,
  input  logic                     bos,
  output logic [DEPTH*LABEL_W-1:0] keys_next,
  output logic                     el_found_next,
  output logic [LABEL_W-1:0]       el_next
);
  logic [LABEL_W-1:0] hist_q [DEPTH];
  logic [LABEL_W-1:0] hist_n [DEPTH];
  logic               eli_pend_q, el_found_q;
  logic [LABEL_W-1:0] el_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hist
    if (g == 0) begin : g_head
      assign hist_n[g] = push ? label : hist_q[g];
    end else begin : g_tail
      assign hist_n[g] = push ? hist_q[g-1] : hist_q[g];
    end
    assign keys_next[g*LABEL_W +: LABEL_W] = hist_n[g];

    always_ff @(posedge clk) begin
      if (!rst_n || clear) hist_q[g] <= '0;
      else                 hist_q[g] <= hist_n[g];
    end
  end

  // the entry after an indicator becomes the entropy label (deepest pair wins)
  assign el_found_next = el_found_q || (push && eli_pend_q);
  assign el_next       = (push && eli_pend_q) ? label : el_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      eli_pend_q <= 1'b0;
      el_found_q <= 1'b0;
      el_q       <= '0;
    end else begin
      el_found_q <= el_found_next;
      el_q       <= el_next;
      if (push) eli_pend_q <= (label == ELI_VALUE) && !bos;
    end
  end

  assert_pending_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eli_pend_q && push && !clear) |=> el_found_q);
endmodule

// File: rtl/lss_ip_grab.sv
module lss_ip_grab
  import lss_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                take,
  input  logic [7:0]          byte_in,
  output logic                done_now,
  output key_kind_e           kind_next,
  output logic [IP_KEY_W-1:0] ip_next
);
  localparam int PC_W = $clog2(V6_LAST + 2);

  logic [PC_W-1:0]     pcnt_q;
  key_kind_e           ver_q, ver_cur;
  logic [IP_KEY_W-1:0] ip_q;
  logic                in_v4, in_v6, cap;

  always_comb begin
    ver_cur = ver_q;
    if (pcnt_q == '0) begin
      case (byte_in[7:4])
        4'd4:    ver_cur = KIND_IPV4;
        4'd6:    ver_cur = KIND_IPV6;
        default: ver_cur = KIND_LABELS;
      endcase
    end
  end

  assign in_v4 = (ver_cur == KIND_IPV4) && (pcnt_q >= PC_W'(V4_FIRST)) && (pcnt_q <= PC_W'(V4_LAST));
  assign in_v6 = (ver_cur == KIND_IPV6) && (pcnt_q >= PC_W'(V6_FIRST)) && (pcnt_q <= PC_W'(V6_LAST));
  assign cap   = take && (in_v4 || in_v6);

  assign ip_next   = cap ? {ip_q[IP_KEY_W-9:0], byte_in} : ip_q;
  assign kind_next = ver_cur;
  assign done_now  = take && ((ver_cur == KIND_LABELS)
                   || ((ver_cur == KIND_IPV4) && pcnt_q == PC_W'(V4_LAST))
                   || ((ver_cur == KIND_IPV6) && pcnt_q == PC_W'(V6_LAST)));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pcnt_q <= '0;
      ver_q  <= KIND_LABELS;
      ip_q   <= '0;
    end else if (take) begin
      pcnt_q <= pcnt_q + PC_W'(1);
      ver_q  <= ver_cur;
      ip_q   <= ip_next;
    end
  end

  assert_v4_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ver_q == KIND_IPV4) |-> (pcnt_q <= PC_W'(V4_LAST + 1)));
endmodule

// File: rtl/lstack_scan.sv
module lstack_scan
  import lss_pkg::*;
#(
  parameter int WINDOW    = 8,
  parameter int KEY_DEPTH = 3,
  localparam int DW   = $clog2(WINDOW + 1),
  localparam int KL_W = KEY_DEPTH * 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  input  logic            cfg_slowpath,
  input  logic            cfg_payload_en,
  output logic            res_valid,
  output logic [DW-1:0]   res_depth,
  output logic            res_malformed,
  output logic            res_exception,
  output logic [1:0]      res_kind,
  output logic [KL_W-1:0] res_key_labels,
  output logic [255:0]    res_key_ip
);
  localparam logic [DW-1:0] WIN_D = DW'(WINDOW);

  scan_state_e         state_q;
  logic                accept, take_stack, take_pay, clear_pkt, saw_last_q;
  logic [DW-1:0]       depth_q, depth_inc;
  logic                mal_q, exc_q;
  key_kind_e           kind_q;
  logic [KL_W-1:0]     lbl_q;
  logic [IP_KEY_W-1:0] ip_q;

  logic                entry_done, entry_bos;
  logic [LABEL_W-1:0]  entry_label;
  logic [KL_W-1:0]     keys_next;
  logic                el_found_next;
  logic [LABEL_W-1:0]  el_next;
  logic                grab_done;
  key_kind_e           grab_kind;
  logic [IP_KEY_W-1:0] grab_ip;

  assign in_ready   = (state_q != ST_RESULT);
  assign accept     = in_valid && in_ready;
  assign take_stack = accept && (state_q == ST_STACK);
  assign take_pay   = accept && (state_q == ST_PAYLOAD);
  assign clear_pkt  = ((state_q == ST_RESULT) && saw_last_q)
                   || ((state_q == ST_DRAIN) && accept && in_last);
  assign depth_inc  = depth_q + DW'(1);

  lss_entry_collect u_collect (
    .clk, .rst_n, .clear(clear_pkt), .take(take_stack), .byte_in(in_data),
    .entry_done, .entry_label, .entry_bos
  );

  lss_label_history #(.DEPTH(KEY_DEPTH)) u_hist (
    .clk, .rst_n, .clear(clear_pkt), .push(entry_done), .label(entry_label),
    .bos(entry_bos), .keys_next, .el_found_next, .el_next
  );

  lss_ip_grab u_grab (
    .clk, .rst_n, .clear(clear_pkt), .take(take_pay), .byte_in(in_data),
    .done_now(grab_done), .kind_next(grab_kind), .ip_next(grab_ip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_STACK;
      saw_last_q <= 1'b0;
      depth_q    <= '0;
      mal_q      <= 1'b0;
      exc_q      <= 1'b0;
      kind_q     <= KIND_LABELS;
      lbl_q      <= '0;
      ip_q       <= '0;
    end else begin
      case (state_q)
        ST_STACK: if (take_stack) begin
          if (entry_done && entry_bos) begin
            depth_q <= depth_inc;
            ip_q    <= '0;
            if (el_found_next) begin
              lbl_q  <= KL_W'(el_next);
              kind_q <= KIND_ENTROPY;
            end else begin
              lbl_q  <= keys_next;
              kind_q <= KIND_LABELS;
            end
            if (el_found_next || !cfg_payload_en || in_last) begin
              state_q    <= ST_RESULT;
              saw_last_q <= in_last;
            end else begin
              state_q <= ST_PAYLOAD;
            end
          end else if (entry_done && depth_inc == WIN_D) begin
            depth_q    <= depth_inc;
            mal_q      <= !cfg_slowpath;
            exc_q      <= cfg_slowpath;
            lbl_q      <= '0;
            ip_q       <= '0;
            kind_q     <= KIND_LABELS;
            state_q    <= ST_RESULT;
            saw_last_q <= in_last;
          end else if (in_last) begin
            depth_q    <= entry_done ? depth_inc : depth_q;
            mal_q      <= 1'b1;
            lbl_q      <= '0;
            ip_q       <= '0;
            kind_q     <= KIND_LABELS;
            state_q    <= ST_RESULT;
            saw_last_q <= 1'b1;
          end else if (entry_done) begin
            depth_q <= depth_inc;
          end
        end
        ST_PAYLOAD: if (take_pay) begin
          if (grab_done) begin
            kind_q     <= grab_kind;
            ip_q       <= grab_ip;
            state_q    <= ST_RESULT;
            saw_last_q <= in_last;
          end else if (in_last) begin
            kind_q     <= KIND_LABELS;
            ip_q       <= '0;
            state_q    <= ST_RESULT;
            saw_last_q <= 1'b1;
          end
        end
        ST_RESULT: begin
          state_q <= saw_last_q ? ST_STACK : ST_DRAIN;
          if (saw_last_q) begin
            depth_q <= '0;
            mal_q   <= 1'b0;
            exc_q   <= 1'b0;
          end
        end
        default: if (accept && in_last) begin
          state_q <= ST_STACK;
          depth_q <= '0;
          mal_q   <= 1'b0;
          exc_q   <= 1'b0;
        end
      endcase
    end
  end

  assign res_valid      = (state_q == ST_RESULT);
  assign res_depth      = depth_q;
  assign res_malformed  = mal_q;
  assign res_exception  = exc_q;
  assign res_kind       = kind_q;
  assign res_key_labels = lbl_q;
  assign res_key_ip     = ip_q;

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_malformed && res_exception));
  assert_flagged_key_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_malformed || res_exception)) |-> (res_key_labels == '0 && res_key_ip == '0));
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_depth_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_depth <= WIN_D);
  assert_exc_full_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_exception) |-> (res_depth == WIN_D));
  assert_entropy_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == KIND_ENTROPY) |-> ((res_key_labels >> LABEL_W) == '0 && res_key_ip == '0));
endmodule

// File: tb/lstack_scan_test.sv
module lstack_scan_test;
  localparam int WIN = 8;
  localparam int NP  = 128;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, cfg_slowpath = 0, cfg_payload_en = 0;
  logic [7:0] in_data = 0;
  logic in_ready, res_valid, res_malformed, res_exception;
  logic [3:0] res_depth;
  logic [1:0] res_kind;
  logic [59:0] res_key_labels;
  logic [255:0] res_key_ip;

  lstack_scan #(.WINDOW(WIN), .KEY_DEPTH(3)) uut (.*);

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int sent = 0, res_idx = 0, acc_pkt = 0;
  int acc_cnt [NP];
  int e_dep [NP], e_dec [NP];
  bit e_mal [NP], e_exc [NP];
  logic [1:0] e_kind [NP];
  logic [59:0] e_lbl [NP];
  logic [255:0] e_ip [NP];
  string e_tag [NP];
  bit running = 0;

  task automatic chk(input bit ok, input string tag, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] b[$], input bit slow, input bit pay,
                       output int dep, output bit mal, output bit exc, output logic [1:0] kind,
                       output logic [59:0] lbl, output logic [255:0] ip, output int dec);
    int n, i, need, first;
    logic [19:0] h0, h1, h2, el, lab;
    bit elp, elf, bos;
    logic [3:0] nib;
    n = b.size(); i = 0; h0 = 0; h1 = 0; h2 = 0; el = 0; elp = 0; elf = 0;
    dep = 0; mal = 0; exc = 0; kind = 0; lbl = 0; ip = 0; dec = n - 1;
    forever begin
      if (n - i < 4) begin mal = 1; dec = n - 1; return; end
      lab = {b[i], b[i+1], b[i+2][7:4]}; bos = b[i+2][0]; i += 4; dep++;
      h2 = h1; h1 = h0; h0 = lab;
      if (elp) begin el = lab; elf = 1; end
      elp = (lab == 20'd7) && !bos;
      if (bos) begin
        lbl = elf ? {40'b0, el} : {h2, h1, h0};
        kind = elf ? 2'd3 : 2'd0; dec = i - 1;
        if (elf || !pay || i >= n) return;
        nib = b[i][7:4];
        if (nib == 4) begin need = 20; first = 12; end
        else if (nib == 6) begin need = 40; first = 8; end
        else begin dec = i; return; end
        if (n - i < need) begin dec = n - 1; return; end
        for (int k = first; k < need; k++) ip = {ip[247:0], b[i+k]};
        kind = (nib == 4) ? 2'd1 : 2'd2; dec = i + need - 1; return;
      end
      if (dep == WIN) begin
        if (slow) exc = 1; else mal = 1;
        dec = i - 1; return;
      end
      if (i >= n) begin mal = 1; dec = n - 1; return; end
    end
  endtask

  // per-cycle comparison, sampled mid-cycle
  always @(negedge clk) begin
    #2;
    if (running) begin
      chk(in_ready == !res_valid, "R10", "ready vs strobe", in_ready, !res_valid);
      if (res_valid) begin
        if (res_idx >= sent) chk(0, "R10", "unexpected result", res_idx, sent);
        else begin
          string t; t = e_tag[res_idx];
          chk(acc_cnt[res_idx] == e_dec[res_idx] + 1, t, "result cycle (bytes taken)", acc_cnt[res_idx], e_dec[res_idx] + 1);
          chk(res_depth == e_dep[res_idx], t, "depth", res_depth, e_dep[res_idx]);
          chk(res_malformed == e_mal[res_idx], t, "malformed", res_malformed, e_mal[res_idx]);
          chk(res_exception == e_exc[res_idx], t, "exception", res_exception, e_exc[res_idx]);
          chk(res_kind == e_kind[res_idx], t, "kind", res_kind, e_kind[res_idx]);
          chk(res_key_labels == e_lbl[res_idx], t, "key labels", res_key_labels, e_lbl[res_idx]);
          chk(res_key_ip == e_ip[res_idx], t, "key ip", res_key_ip, e_ip[res_idx]);
        end
        res_idx++;
      end
      if (in_valid && in_ready) begin
        acc_cnt[acc_pkt]++;
        if (in_last) acc_pkt++;
      end
    end
  end

  function automatic void add_lse(ref logic [7:0] q[$], input logic [19:0] lab, input bit bos);
    logic [31:0] e;
    e = {lab, 3'd5, bos, 8'd64};
    q.push_back(e[31:24]); q.push_back(e[23:16]); q.push_back(e[15:8]); q.push_back(e[7:0]);
  endfunction

  function automatic void add_pay(ref logic [7:0] q[$], input logic [3:0] nib, input int len);
    for (int k = 0; k < len; k++) q.push_back(k == 0 ? {nib, 4'h5} : 8'(8'h30 + k * 7));
  endfunction

  task automatic run_pkt(input logic [7:0] b[$], input bit slow, input bit pay, input string tag);
    int idx;
    idx = sent;
    cfg_slowpath = slow; cfg_payload_en = pay;
    model(b, slow, pay, e_dep[idx], e_mal[idx], e_exc[idx], e_kind[idx], e_lbl[idx], e_ip[idx], e_dec[idx]);
    e_tag[idx] = tag; acc_cnt[idx] = 0;
    sent++;
    foreach (b[k]) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin in_valid = 0; @(negedge clk); end
      in_valid = 1; in_data = b[k]; in_last = (k == b.size() - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    while (res_idx <= idx) @(negedge clk);
  endtask

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    // reset state (R10)
    #2;
    chk(res_valid == 0, "R10", "reset strobe", res_valid, 0);
    chk(in_ready == 1, "R10", "reset ready", in_ready, 1);
    rst_n = 1;
    running = 1;

    q = {}; add_lse(q, 20'h12345, 1); run_pkt(q, 0, 0, "R1");
    q = {}; for (int e = 0; e < 5; e++) add_lse(q, 20'h100 + e, e == 4); run_pkt(q, 0, 0, "R4");
    q = {}; add_lse(q, 20'hABCDE, 0); add_lse(q, 20'h00042, 1); run_pkt(q, 0, 0, "R4");
    q = {}; for (int e = 0; e < WIN; e++) add_lse(q, 20'h200 + e, e == WIN - 1); run_pkt(q, 1, 0, "R2");
    q = {}; for (int e = 0; e < WIN + 2; e++) add_lse(q, 20'h300 + e, 0); run_pkt(q, 0, 0, "R3");
    q = {}; for (int e = 0; e < WIN + 1; e++) add_lse(q, 20'h400 + e, e == WIN); run_pkt(q, 1, 0, "R3");
    q = {}; add_lse(q, 20'h11, 0); add_lse(q, 20'h7, 0); add_lse(q, 20'hBEEF1, 0); add_lse(q, 20'h22, 1);
      add_pay(q, 4, 24); run_pkt(q, 0, 1, "R5");
    q = {}; add_lse(q, 20'h7, 0); add_lse(q, 20'h0AAAA, 0); add_lse(q, 20'h7, 0); add_lse(q, 20'h0BBBB, 1);
      run_pkt(q, 0, 0, "R5");
    q = {}; add_lse(q, 20'h33, 0); add_lse(q, 20'h7, 1); run_pkt(q, 0, 0, "R5");
    q = {}; add_lse(q, 20'h55, 0); add_lse(q, 20'h66, 1); add_pay(q, 4, 20); run_pkt(q, 0, 1, "R6");
    q = {}; add_lse(q, 20'h77, 1); add_pay(q, 4, 30); run_pkt(q, 0, 1, "R6");
    q = {}; add_lse(q, 20'h88, 1); add_pay(q, 6, 40); run_pkt(q, 0, 1, "R7");
    q = {}; add_lse(q, 20'h99, 1); add_pay(q, 5, 30); run_pkt(q, 0, 1, "R8");
    q = {}; add_lse(q, 20'h9A, 1); add_pay(q, 4, 30); run_pkt(q, 0, 0, "R8");
    q = {}; add_lse(q, 20'h9B, 1); add_pay(q, 6, 25); run_pkt(q, 0, 1, "R8");
    q = {}; add_lse(q, 20'h9C, 1); run_pkt(q, 0, 1, "R8");
    q = {}; add_lse(q, 20'h1, 0); add_lse(q, 20'h2, 0); q.push_back(8'h12); q.push_back(8'h34);
      run_pkt(q, 1, 0, "R9");
    q = {}; add_lse(q, 20'h1, 0); add_lse(q, 20'h2, 0); add_lse(q, 20'h3, 0); run_pkt(q, 1, 0, "R9");

    for (int p = 0; p < 50; p++) begin
      int nent, plen;
      q = {};
      nent = $urandom_range(1, WIN + 3);
      for (int e = 0; e < nent; e++)
        add_lse(q, ($urandom_range(0, 5) == 0) ? 20'd7 : 20'($urandom),
                (e == nent - 1) && ($urandom_range(0, 4) != 0));
      plen = $urandom_range(0, 45);
      case ($urandom_range(0, 2))
        0: add_pay(q, 4, plen);
        1: add_pay(q, 6, plen);
        default: add_pay(q, 4'($urandom_range(0, 15)), plen);
      endcase
      run_pkt(q, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R1");
    end

    repeat (4) @(negedge clk);
    chk(res_idx == sent, "R10", "result count", res_idx, sent);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule